// File: doc/BRIEF.md
# Configurable Burst Memory Access Sequencer

This block is the device-side sequencing logic of a synchronous pseudo-SRAM style memory. A single 16-bit bus configuration register sets several things together: the latency before the first data word, how the WAIT output behaves (its polarity, and whether it leads or lines up with the stall), whether bursts wrap, and how long bursts are. The register is loaded through a configuration write. The write carries a two-bit register-select code, and only one code value reaches this register.

Once the host issues a command, the sequencer counts the latency clocks. In variable-latency mode, a stall input can stretch that count. The sequencer then steps through the word addresses of the burst, strobing data-valid for each word, and stops after the programmed number of words or when the host terminates the command. The WAIT output covers every cycle without data, following the programmed polarity and timing. The storage array, refresh, asynchronous timing and output drive strength are outside this block. The drive field is only held in the register.

Top module: `bseq_top`

## Requirements
- R1: After reset, cfg_value reads 0x1D1F, cfg_err is 0, busy and data_valid are 0, and wait_o sits at its inactive level. The reset value means active-high WAIT, so wait_o is 0.
- R2: A configuration write (cfg_we=1) loads the register only when cfg_sel is 2'b10. The select codes 2'b00 and 2'b01 leave cfg_value unchanged.
- R3: Only the implemented fields are stored: bit 15 (1 = asynchronous), bit 14 (1 = fixed latency), bits 13:11 (latency code), bit 10 (WAIT polarity), bit 8 (WAIT early), bits 5:4 (drive) and bit 3 (1 = no wrap). Bits 9, 7 and 6 always read 0.
- R4: A write whose latency code is 001 or 111 keeps the old bits 13:11. A write whose burst code is not 001, 010, 011 or 111 keeps the old bits 2:0. Either case sets cfg_err, which stays set until reset. The other fields of that write are still stored.
- R5: The latency codes map as follows: 000 gives L=9, 010 gives 3, 011 gives 4, 100 gives 5, 101 gives 6 and 110 gives 7. A start is accepted in cycle c when the block is idle and bit 15 is 0. The block then spends L latency cycles, and data_valid first rises in cycle c+L+1. data_write repeats the cmd_write captured at start.
- R6: With bit 14 = 0, every latency cycle with lat_stall=1 does not count, so the latency is extended. With bit 14 = 1, lat_stall has no effect.
- R7: wait_o equals the internal WAIT-active term when bit 10 = 1 and its inverse when bit 10 = 0. When idle or delivering data, the term is inactive.
- R8: With bit 8 = 0, WAIT is active in every latency cycle. With bit 8 = 1, WAIT goes inactive in the last latency cycle, one cycle before the first data word. A stalled cycle is never the last latency cycle.
- R9: The burst codes map as 001 = 4, 010 = 8, 011 = 16 and 111 = continuous. With bit 3 = 0 and a fixed length N, each step increments the address modulo N inside the N-aligned window.
- R10: With bit 3 = 1 and a fixed length N, the address increments linearly, wrapping only at 2^AW. After N data words the block returns to idle. This holds for both reads and writes.
- R11: In continuous mode the address increments linearly whatever bit 3 holds, and data continues until cmd_end.
- R12: cmd_end during latency or data returns the block to idle on the next cycle. cmd_start is ignored while busy, and also ignored when bit 15 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select code (2'b10 = this register) |
| cfg_wdata | input | 16 | Configuration write data |
| cmd_start | input | 1 | Begin a burst command |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | AW | Starting word address |
| cmd_end | input | 1 | Terminate the current command |
| lat_stall | input | 1 | Stretch the initial latency by one cycle (variable mode) |
| busy | output | 1 | Command in progress |
| data_valid | output | 1 | Current cycle carries a data word |
| data_write | output | 1 | Direction of the burst in progress |
| word_addr | output | AW | Address of the current data word |
| wait_o | output | 1 | WAIT with the programmed polarity and timing |
| cfg_value | output | 16 | Current configuration register contents |
| cfg_err | output | 1 | Sticky reserved-code write flag |

## Verification
Assertions run on every cycle and check the following:
- the error flag never clears, and a write with a foreign select never changes the register;
- a stored latency code is never reserved;
- WAIT sits at its inactive level whenever the block is idle;
- asynchronous mode blocks starts;
- fixed latency counts down through stalls;
- wrap mode keeps consecutive addresses inside their window, and continuous mode steps linearly.

Some behaviours can only be shown by the bench scenarios, which compare against a behavioural model on every clock. These are:
- the exact cycle of the first data word for each latency code, including stall stretching;
- where early and aligned WAIT fall;
- the full address order in wrap and no-wrap bursts, including the word count at which a burst ends;
- that reserved codes keep their old fields while the rest of the write lands.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAT  = 2'd1,
        ST_DATA = 2'd2
    } bseq_state_e;

    localparam logic [15:0] CFG_RESET   = 16'h1D1F;
    localparam logic [15:0] CFG_STORED  = 16'hFD3F;
    localparam logic [1:0]  SEL_BUS_CFG = 2'b10;
    localparam int          CNT_W       = 5;

    function automatic logic lat_code_ok(input logic [2:0] code);
        return !(code == 3'b001 || code == 3'b111);
    endfunction

    function automatic logic [CNT_W-1:0] lat_cycles(input logic [2:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            3'b000:  n = 5'd9;
            3'b010:  n = 5'd3;
            3'b011:  n = 5'd4;
            3'b100:  n = 5'd5;
            3'b101:  n = 5'd6;
            3'b110:  n = 5'd7;
            default: n = 5'd4;
        endcase
        return n;
    endfunction

    function automatic logic blen_code_ok(input logic [2:0] code);
        return (code == 3'b001) || (code == 3'b010) ||
               (code == 3'b011) || (code == 3'b111);
    endfunction

    // zero means continuous
    function automatic logic [CNT_W-1:0] blen_words(input logic [2:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            3'b001:  n = 5'd4;
            3'b010:  n = 5'd8;
            3'b011:  n = 5'd16;
            default: n = 5'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bseq_cfg_reg.sv
module bseq_cfg_reg
    import bseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  sel,
    input  logic [15:0] wdata,
    output logic [15:0] cfg_q,
    output logic        err_q
);

    typedef struct packed {
        logic [15:0] cfg;
        logic        err;
    } cfg_s;

    cfg_s cur_q, nxt_d;
    logic [15:0] val_d;

    always_comb begin
        nxt_d = cur_q;
        val_d = wdata & CFG_STORED;
        if (we && sel == SEL_BUS_CFG) begin
            if (!lat_code_ok(wdata[13:11])) begin
                val_d[13:11] = cur_q.cfg[13:11];
                nxt_d.err    = 1'b1;
            end
            if (!blen_code_ok(wdata[2:0])) begin
                val_d[2:0] = cur_q.cfg[2:0];
                nxt_d.err  = 1'b1;
            end
            nxt_d.cfg = val_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.cfg <= CFG_RESET;
            cur_q.err <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cfg_q = cur_q.cfg;
    assign err_q = cur_q.err;

    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    a_r2_foreign_sel_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel != SEL_BUS_CFG) |=> $stable(cfg_q));

    a_r4_lat_field_valid: assert property (@(posedge clk) disable iff (!rst_n)
        lat_code_ok(cfg_q[13:11]) && blen_code_ok(cfg_q[2:0]));

endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
    import bseq_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic [AW-1:0]    addr,
    input  logic             wrap_en,
    input  logic [CNT_W-1:0] words,
    output logic [AW-1:0]    addr_next,
    output logic [AW-1:0]    win_mask
);

    localparam int PAD_W = AW - CNT_W;

    logic [AW-1:0] inc;

    always_comb begin
        inc      = addr + 1'b1;
        win_mask = {{PAD_W{1'b0}}, words - 1'b1};
        if (words == '0 || !wrap_en) begin
            addr_next = inc;
        end else begin
            addr_next = (addr & ~win_mask) | (inc & win_mask);
        end
    end

endmodule

// File: rtl/bseq_wait_gen.sv
module bseq_wait_gen (
    input  logic lat_phase,
    input  logic last_lat,
    input  logic early,
    input  logic pol_high,
    output logic wait_act,
    output logic wait_pin
);

    always_comb begin
        wait_act = lat_phase && !(early && last_lat);
        wait_pin = pol_high ? wait_act : !wait_act;
    end

endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [15:0]   cfg_wdata,
    input  logic          cmd_start,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic          cmd_end,
    input  logic          lat_stall,
    output logic          busy,
    output logic          data_valid,
    output logic          data_write,
    output logic [AW-1:0] word_addr,
    output logic          wait_o,
    output logic [15:0]   cfg_value,
    output logic          cfg_err
);

    typedef struct packed {
        bseq_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic             wr;
    } seq_s;

    seq_s cur_q, nxt_d;

    logic [15:0]      cfg;
    logic             async_mode, fixed_lat, no_wrap;
    logic [CNT_W-1:0] burst_words;
    logic [AW-1:0]    addr_step, win_mask;
    logic             lat_hold, last_lat, wait_act;

    bseq_cfg_reg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg_q (cfg),
        .err_q (cfg_err)
    );

    assign async_mode  = cfg[15];
    assign fixed_lat   = cfg[14];
    assign no_wrap     = cfg[3];
    assign burst_words = blen_words(cfg[2:0]);

    bseq_addr_gen #(.AW(AW)) i_addr (
        .addr      (cur_q.addr),
        .wrap_en   (!no_wrap),
        .words     (burst_words),
        .addr_next (addr_step),
        .win_mask  (win_mask)
    );

    assign lat_hold = lat_stall && !fixed_lat;
    assign last_lat = (cur_q.state == ST_LAT) && (cur_q.cnt == 5'd1) && !lat_hold;

    bseq_wait_gen i_wait (
        .lat_phase (cur_q.state == ST_LAT),
        .last_lat  (last_lat),
        .early     (cfg[8]),
        .pol_high  (cfg[10]),
        .wait_act  (wait_act),
        .wait_pin  (wait_o)
    );

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.state)
            ST_IDLE: begin
                if (cmd_start && !async_mode) begin
                    nxt_d.state = ST_LAT;
                    nxt_d.cnt   = lat_cycles(cfg[13:11]);
                    nxt_d.addr  = cmd_addr;
                    nxt_d.wr    = cmd_write;
                end
            end
            ST_LAT: begin
                if (cmd_end) begin
                    nxt_d.state = ST_IDLE;
                end else if (!lat_hold) begin
                    if (cur_q.cnt == 5'd1) begin
                        nxt_d.state = ST_DATA;
                        nxt_d.cnt   = burst_words;
                    end else begin
                        nxt_d.cnt = cur_q.cnt - 1'b1;
                    end
                end
            end
            ST_DATA: begin
                nxt_d.addr = addr_step;
                if (cmd_end) begin
                    nxt_d.state = ST_IDLE;
                end else if (cur_q.cnt != '0) begin
                    if (cur_q.cnt == 5'd1) begin
                        nxt_d.state = ST_IDLE;
                    end
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.cnt   <= '0;
            cur_q.addr  <= '0;
            cur_q.wr    <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy       = cur_q.state != ST_IDLE;
    assign data_valid = cur_q.state == ST_DATA;
    assign data_write = cur_q.wr;
    assign word_addr  = cur_q.addr;
    assign cfg_value  = cfg;

    a_r7_idle_wait_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (wait_o == !cfg[10]));

    a_r8_no_wait_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> !wait_act);

    a_r12_async_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start && async_mode) |=> !busy);

    a_r6_fixed_ignores_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_LAT && fixed_lat && cur_q.cnt > 5'd1 && !cmd_end)
        |=> (cur_q.cnt == $past(cur_q.cnt) - 1'b1));

    a_r9_wrap_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $past(data_valid) && !no_wrap && burst_words != '0
         && $stable(cfg))
        |-> ((word_addr & ~win_mask) == ($past(word_addr) & ~win_mask)));

    a_r11_continuous_linear: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $past(data_valid) && burst_words == '0)
        |-> (word_addr == $past(word_addr) + 1'b1));

endmodule

// File: tb/test_bseq_top.sv
`timescale 1ns/1ps
module test_bseq_top;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'b00;
    logic [15:0]   cfg_wdata = 16'h0;
    logic          cmd_start = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_end = 1'b0;
    logic          lat_stall = 1'b0;
    logic          busy, data_valid, data_write, wait_o, cfg_err;
    logic [AW-1:0] word_addr;
    logic [15:0]   cfg_value;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural model state
    int            m_st;   // 0 idle, 1 latency, 2 data
    int            m_cnt;
    logic [AW-1:0] m_addr;
    bit            m_wr;
    logic [15:0]   m_cfg;
    bit            m_err;

    always #10 clk = ~clk;

    bseq_top #(.AW(AW)) i_bseq_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_end(cmd_end), .lat_stall(lat_stall),
        .busy(busy), .data_valid(data_valid), .data_write(data_write),
        .word_addr(word_addr), .wait_o(wait_o), .cfg_value(cfg_value),
        .cfg_err(cfg_err)
    );

    function automatic int lat_of(input logic [2:0] c);
        case (c)
            3'b000: return 9;
            3'b010: return 3;
            3'b011: return 4;
            3'b100: return 5;
            3'b101: return 6;
            default: return 7;
        endcase
    endfunction

    function automatic int len_of(input logic [2:0] c);
        if (c == 3'b001) return 4;
        if (c == 3'b010) return 8;
        if (c == 3'b011) return 16;
        return 0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_cnt = 0; m_addr = '0; m_wr = 0;
        m_cfg = 16'h1D1F; m_err = 0;
    endtask

    // one clock: inputs already driven; compare, advance model, then edge
    task automatic step();
        bit   hold, last, act, nxt_busy;
        int   len;
        logic [15:0] v;
        #1;
        hold = lat_stall && !m_cfg[14];
        last = (m_st == 1) && (m_cnt == 1) && !hold;
        act  = (m_st == 1) && !(m_cfg[8] && last);
        chk("R10 R11 R12 busy", busy, m_st != 0);
        chk("R5 R6 data_valid", data_valid, m_st == 2);
        if (m_st == 2) begin
            chk("R9 R10 R11 word_addr", word_addr, m_addr);
            chk("R5 R10 data_write", data_write, m_wr);
        end
        chk("R7 R8 wait_o", wait_o, m_cfg[10] ? act : !act);
        chk("R2 R3 cfg_value", cfg_value, m_cfg);
        chk("R4 cfg_err", cfg_err, m_err);
        len = len_of(m_cfg[2:0]);
        nxt_busy = 0;
        if (m_st == 0) begin
            if (cmd_start && !m_cfg[15]) begin
                m_st = 1; m_cnt = lat_of(m_cfg[13:11]);
                m_addr = cmd_addr; m_wr = cmd_write;
            end
        end else if (m_st == 1) begin
            if (cmd_end) m_st = 0;
            else if (!hold) begin
                if (m_cnt == 1) begin m_st = 2; m_cnt = len; end
                else m_cnt--;
            end
        end else begin
            if (len == 0 || m_cfg[3]) m_addr = m_addr + 1;
            else m_addr = m_addr - (m_addr % len) + ((m_addr % len) + 1) % len;
            if (cmd_end) m_st = 0;
            else if (m_cnt != 0) begin
                if (m_cnt == 1) m_st = 0;
                m_cnt--;
            end
        end
        if (cfg_we && cfg_sel == 2'b10) begin
            v = cfg_wdata & 16'hFD3F;
            if (cfg_wdata[13:11] == 3'b001 || cfg_wdata[13:11] == 3'b111) begin
                v[13:11] = m_cfg[13:11]; m_err = 1;
            end
            if (len_of(cfg_wdata[2:0]) == 0 && cfg_wdata[2:0] != 3'b111) begin
                v[2:0] = m_cfg[2:0]; m_err = 1;
            end
            m_cfg = v;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr_cfg(input logic [1:0] sel, input logic [15:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic start(input logic [AW-1:0] a, input bit w);
        cmd_start = 1'b1; cmd_addr = a; cmd_write = w;
        step();
        cmd_start = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reset cfg_value", cfg_value, 16'h1D1F);
        chk("R1 reset cfg_err", cfg_err, 0);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset wait_o", wait_o, 0);
        @(negedge clk);

        // R5 R8 R11: defaults, latency 4, early WAIT, continuous read
        start(20'h00010, 1'b0);
        run(14);
        cmd_end = 1'b1; step(); cmd_end = 1'b0;
        run(2);

        // R2: foreign selects ignored
        wr_cfg(2'b00, 16'h0000);
        wr_cfg(2'b01, 16'hFFFF);
        run(1);

        // R3 R9 R7: reserved bits dropped; lat 3, active-low, aligned, wrap 4
        wr_cfg(2'b10, 16'h1291);
        start(20'h00006, 1'b0);
        run(10);

        // R6: stall stretches variable latency
        start(20'h00021, 1'b1);
        run(1);
        lat_stall = 1'b1; run(2); lat_stall = 1'b0;
        run(8);

        // R9 R5: lat 9, active-high early, wrap 8, write
        wr_cfg(2'b10, 16'h0512);
        start(20'h0000D, 1'b1);
        lat_stall = 1'b1; run(3); lat_stall = 1'b0;
        run(18);

        // R10 R6: fixed lat 7 with stall ignored, no wrap 16, crosses 2^AW
        wr_cfg(2'b10, 16'h750B);
        start(20'hFFFF8, 1'b0);
        lat_stall = 1'b1; run(4); lat_stall = 1'b0;
        run(22);

        // R11: continuous ignores wrap bit
        wr_cfg(2'b10, 16'h1D17);
        start(20'h0003E, 1'b0);
        run(12);
        // R12: start while busy ignored
        cmd_start = 1'b1; cmd_addr = 20'h00500; step(); cmd_start = 1'b0;
        run(3);
        cmd_end = 1'b1; step(); cmd_end = 1'b0;
        run(1);

        // R12: end during latency
        start(20'h00100, 1'b1);
        run(2);
        cmd_end = 1'b1; step(); cmd_end = 1'b0;
        run(3);

        // R4: reserved latency and burst codes
        wr_cfg(2'b10, 16'h0935);
        run(1);
        wr_cfg(2'b10, 16'h3C14);
        start(20'h00047, 1'b0);
        run(16);

        // R12: asynchronous mode blocks start
        wr_cfg(2'b10, 16'h9D1F);
        start(20'h00010, 1'b0);
        run(3);

        // mixed stall patterns, variable latency, polarity/timing sweep
        for (int k = 0; k < 8; k++) begin
            wr_cfg(2'b10, {1'b0, 1'b0, 3'(2 + (k % 5)), 1'(k & 1), 1'b0,
                           1'((k >> 1) & 1), 4'b0001, 1'((k >> 2) & 1),
                           3'(1 + (k % 3))});
            start(20'(k * 37 + 3), 1'(k & 1));
            for (int j = 0; j < 24; j++) begin
                lat_stall = ((j * 5 + k) % 3) == 0;
                step();
            end
            lat_stall = 1'b0;
            run(2);
        end

        finish_run();
    end

endmodule